// File: doc/BRIEF.md
# Exception and Interrupt Control Register Unit

This unit sits next to a simple CPU pipeline and keeps the state a kernel needs in order to service traps. It holds a status word (interrupt mask, user-mode flag, exception-level flag, global enable), a cause word (delay-slot flag, pending interrupt levels, exception code), the saved exception PC, the last faulting data address and a free-running counter with a compare register that raises a timer interrupt. Software reads and writes these registers by register number through a simple move-to/move-from port.

Each cycle the unit combines a synchronous exception request from the pipeline with the six hardware interrupt lines, two software interrupt levels and the timer. When it decides to take a trap, it raises a redirect strobe in the same cycle and presents a fixed handler address. On the following clock edge it records the code, the return address and the exception-level flag. A return-from-exception pulse only clears the exception-level flag.

Top module: `exc_unit`

## Requirements
- R1: Reads by register number return bad address (8), counter (9), compare (11), status (12), cause (13) and exception PC (14); any other number reads 0; compare and exception PC are writable.
- R2: Status holds the mask in bits 15:8, user mode in bit 4, exception level in bit 1 and global enable in bit 0; other bits read 0; all fields reset to 0.
- R3: Hardware line k sets cause bit 10+k one clock after it is high, whatever the mask; cause bits 9:8 are software levels written through the cause register; the rest of cause is not writable.
- R4: An interrupt is taken when enable is 1, exception level is 0 and some pending bit has its mask bit set; a pending masked level is taken in the cycle after its mask bit is written to 1.
- R5: A pipeline exception request raises redirect in the same cycle; at the next edge the code appears in cause bits 6:2, the exception PC holds the request PC and exception level becomes 1.
- R6: A taken interrupt records code 0 and saves the supplied next-instruction address as exception PC.
- R7: While exception level is 1, interrupts are not taken, and a new exception still redirects and updates the code but leaves exception PC and the delay-slot bit unchanged.
- R8: An exception in a delay slot saves request PC minus 4 and sets cause bit 31; one outside a delay slot clears it.
- R9: The bad-address register loads the supplied address only for codes 4 and 5.
- R10: The handler address output is always 0x80000180.
- R11: The counter increments every clock; a write loads the written value.
- R12: When counter equals compare, cause bit 15 (hardware level 5) becomes pending and stays so until compare is written.
- R13: Return-from-exception clears exception level; a pipeline exception wins over a pending interrupt in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Pipeline exception request |
| exc_code_i | input | 5 | Code of the requested exception |
| exc_pc_i | input | 32 | Address of the offending instruction |
| exc_bd_i | input | 1 | Offending instruction is in a delay slot |
| exc_addr_i | input | 32 | Faulting data address |
| next_pc_i | input | 32 | Address of the next instruction, saved on interrupts |
| hw_irq_i | input | 6 | Hardware interrupt lines |
| eret_i | input | 1 | Return from exception, clears exception level |
| reg_we_i | input | 1 | Register write strobe |
| reg_num_i | input | 5 | Register number |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| redirect_o | output | 1 | Trap taken this cycle |
| handler_pc_o | output | 32 | Handler entry address |

## Verification
The bench holds a hardware line high with its mask cleared and checks that the pending bit shows while no trap fires. It then sets the mask and expects the trap one cycle later; a design that gated pending by the mask would lose the interrupt. A second exception inside the handler must leave the saved PC and the delay-slot bit unchanged, and a design that ignored the exception level would overwrite the return address. The bench also checks the delay-slot minus-4 return address, that only address errors load the bad address, that an exception beats a pending interrupt in the same cycle, and the exact cycle at which the counter-compare match becomes pending.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam logic [4:0] REG_BADVA   = 5'd8;
  localparam logic [4:0] REG_COUNT   = 5'd9;
  localparam logic [4:0] REG_COMPARE = 5'd11;
  localparam logic [4:0] REG_STATUS  = 5'd12;
  localparam logic [4:0] REG_CAUSE   = 5'd13;
  localparam logic [4:0] REG_EPC     = 5'd14;

  localparam logic [4:0] CODE_INT  = 5'd0;
  localparam logic [4:0] CODE_ADEL = 5'd4;
  localparam logic [4:0] CODE_ADES = 5'd5;

  localparam int unsigned IP_LO   = 8;
  localparam int unsigned UM_BIT  = 4;
  localparam int unsigned EXL_BIT = 1;
  localparam int unsigned IE_BIT  = 0;
  localparam int unsigned BD_BIT  = 31;
  localparam int unsigned CODE_LO = 2;
endpackage

// File: rtl/exc_timer.sv
module exc_timer #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cnt_we_i,
  input  logic            cmp_we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] count_o,
  output logic [XLEN-1:0] compare_o,
  output logic            irq_o
);
  logic [XLEN-1:0] count_q, compare_q;
  logic            pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      compare_q <= '1;  // far from count so no match right after reset
      pend_q    <= 1'b0;
    end else begin
      count_q <= cnt_we_i ? wdata_i : count_q + 1'b1;
      if (cmp_we_i) begin
        compare_q <= wdata_i;
        pend_q    <= 1'b0;
      end else if (count_q == compare_q) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign count_o   = count_q;
  assign compare_o = compare_q;
  assign irq_o     = pend_q;
endmodule

// File: rtl/exc_pending.sv
module exc_pending #(
  parameter int unsigned N_HW      = 6,
  parameter int unsigned N_SW      = 2,
  parameter int unsigned TIMER_LVL = 5,
  localparam int unsigned N_IP     = N_HW + N_SW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_HW-1:0] hw_irq_i,
  input  logic            timer_irq_i,
  input  logic            sw_we_i,
  input  logic [N_SW-1:0] sw_wdata_i,
  output logic [N_IP-1:0] ip_o
);
  logic [N_HW-1:0] hw_q, hw_eff;
  logic [N_SW-1:0] sw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q <= '0;
      sw_q <= '0;
    end else begin
      hw_q <= hw_irq_i;
      if (sw_we_i) sw_q <= sw_wdata_i;
    end
  end

  for (genvar k = 0; k < N_HW; k++) begin : g_lvl
    if (k == TIMER_LVL) begin : g_tmr
      assign hw_eff[k] = hw_q[k] | timer_irq_i;
    end else begin : g_plain
      assign hw_eff[k] = hw_q[k];
    end
  end

  assign ip_o = {hw_eff, sw_q};
endmodule

// File: rtl/exc_take.sv
module exc_take #(
  parameter int unsigned N_IP = 8
) (
  input  logic            exc_valid_i,
  input  logic            ie_i,
  input  logic            exl_i,
  input  logic [N_IP-1:0] ip_i,
  input  logic [N_IP-1:0] im_i,
  output logic            take_o,
  output logic            irq_sel_o
);
  logic irq_req;
  assign irq_req   = ie_i & ~exl_i & (|(ip_i & im_i));
  // synchronous exceptions have priority over interrupts
  assign irq_sel_o = ~exc_valid_i & irq_req;
  assign take_o    = exc_valid_i | irq_req;
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned N_HW      = 6,
  parameter int unsigned N_SW      = 2,
  parameter int unsigned TIMER_LVL = 5,
  parameter logic [31:0] HANDLER   = 32'h8000_0180
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        exc_valid_i,
  input  logic [4:0]  exc_code_i,
  input  logic [31:0] exc_pc_i,
  input  logic        exc_bd_i,
  input  logic [31:0] exc_addr_i,
  input  logic [31:0] next_pc_i,
  input  logic [5:0]  hw_irq_i,
  input  logic        eret_i,
  input  logic        reg_we_i,
  input  logic [4:0]  reg_num_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        redirect_o,
  output logic [31:0] handler_pc_o
);
  localparam int unsigned N_IP = N_HW + N_SW;

  logic [N_IP-1:0] im_q, ip;
  logic            um_q, exl_q, ie_q, bd_q;
  logic [4:0]      code_q, code_nxt;
  logic [XLEN-1:0] epc_q, badva_q, epc_nxt, count, compare;
  logic            timer_irq, take, irq_sel;
  logic            wr_status, wr_cause, wr_epc, wr_count, wr_compare;

  assign wr_status  = reg_we_i && reg_num_i == REG_STATUS;
  assign wr_cause   = reg_we_i && reg_num_i == REG_CAUSE;
  assign wr_epc     = reg_we_i && reg_num_i == REG_EPC;
  assign wr_count   = reg_we_i && reg_num_i == REG_COUNT;
  assign wr_compare = reg_we_i && reg_num_i == REG_COMPARE;

  exc_timer #(.XLEN(XLEN)) u_timer (
    .clk_i, .rst_ni,
    .cnt_we_i (wr_count),
    .cmp_we_i (wr_compare),
    .wdata_i  (reg_wdata_i),
    .count_o  (count),
    .compare_o(compare),
    .irq_o    (timer_irq)
  );

  exc_pending #(.N_HW(N_HW), .N_SW(N_SW), .TIMER_LVL(TIMER_LVL)) u_pend (
    .clk_i, .rst_ni,
    .hw_irq_i,
    .timer_irq_i(timer_irq),
    .sw_we_i    (wr_cause),
    .sw_wdata_i (reg_wdata_i[IP_LO +: N_SW]),
    .ip_o       (ip)
  );

  exc_take #(.N_IP(N_IP)) u_take (
    .exc_valid_i,
    .ie_i     (ie_q),
    .exl_i    (exl_q),
    .ip_i     (ip),
    .im_i     (im_q),
    .take_o   (take),
    .irq_sel_o(irq_sel)
  );

  assign code_nxt = irq_sel ? CODE_INT : exc_code_i;

  always_comb begin
    if (irq_sel)       epc_nxt = next_pc_i;
    else if (exc_bd_i) epc_nxt = exc_pc_i - 32'd4;  // point at the branch
    else               epc_nxt = exc_pc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      im_q    <= '0;
      um_q    <= 1'b0;
      exl_q   <= 1'b0;
      ie_q    <= 1'b0;
      bd_q    <= 1'b0;
      code_q  <= '0;
      epc_q   <= '0;
      badva_q <= '0;
    end else begin
      if (wr_status) begin
        im_q  <= reg_wdata_i[IP_LO +: N_IP];
        um_q  <= reg_wdata_i[UM_BIT];
        exl_q <= reg_wdata_i[EXL_BIT];
        ie_q  <= reg_wdata_i[IE_BIT];
      end
      if (wr_epc) epc_q <= reg_wdata_i;
      if (eret_i) exl_q <= 1'b0;
      if (take) begin
        exl_q  <= 1'b1;
        code_q <= code_nxt;
        if (!exl_q) begin
          epc_q <= epc_nxt;
          bd_q  <= ~irq_sel & exc_bd_i;
        end
        if (!irq_sel && (exc_code_i == CODE_ADEL || exc_code_i == CODE_ADES))
          badva_q <= exc_addr_i;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_num_i)
      REG_BADVA:   reg_rdata_o = badva_q;
      REG_COUNT:   reg_rdata_o = count;
      REG_COMPARE: reg_rdata_o = compare;
      REG_EPC:     reg_rdata_o = epc_q;
      REG_STATUS: begin
        reg_rdata_o[IP_LO +: N_IP] = im_q;
        reg_rdata_o[UM_BIT]        = um_q;
        reg_rdata_o[EXL_BIT]       = exl_q;
        reg_rdata_o[IE_BIT]        = ie_q;
      end
      REG_CAUSE: begin
        reg_rdata_o[BD_BIT]          = bd_q;
        reg_rdata_o[IP_LO +: N_IP]   = ip;
        reg_rdata_o[CODE_LO +: 5]    = code_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign redirect_o   = take;
  assign handler_pc_o = HANDLER;
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        exc_valid_i,
  input logic [4:0]  exc_code_i,
  input logic        redirect_o,
  input logic        exl,
  input logic        ie,
  input logic        any_unmasked,
  input logic [31:0] epc,
  input logic [31:0] badva,
  input logic [31:0] count,
  input logic        count_we,
  input logic        compare_we,
  input logic        timer_irq
);
  // R5
  exc_sets_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |=> exl);

  // R5
  exc_redirects_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |-> redirect_o);

  // R7
  epc_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exl && redirect_o) |=> $stable(epc));

  // R4
  irq_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie && !exl && any_unmasked) |-> redirect_o);

  // R9
  badva_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exc_valid_i || (exc_code_i != 5'd4 && exc_code_i != 5'd5)) |=> $stable(badva));

  // R11
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !count_we |=> count == $past(count) + 32'd1);

  // R12
  timer_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    compare_we |=> !timer_irq);
endmodule

bind exc_unit exc_unit_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .exc_valid_i  (exc_valid_i),
  .exc_code_i   (exc_code_i),
  .redirect_o   (redirect_o),
  .exl          (exl_q),
  .ie           (ie_q),
  .any_unmasked (|(ip & im_q)),
  .epc          (epc_q),
  .badva        (badva_q),
  .count        (count),
  .count_we     (wr_count),
  .compare_we   (wr_compare),
  .timer_irq    (timer_irq)
);

// File: tb/exc_unit_bench.sv
module exc_unit_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        exc_valid_i = 0, exc_bd_i = 0, eret_i = 0, reg_we_i = 0;
  logic [4:0]  exc_code_i = 0, reg_num_i = 0;
  logic [31:0] exc_pc_i = 0, exc_addr_i = 0, next_pc_i = 0, reg_wdata_i = 0;
  logic [5:0]  hw_irq_i = 0;
  logic [31:0] reg_rdata_o, handler_pc_o;
  logic        redirect_o;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  exc_unit u_exc_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic wr(input logic [4:0] n, input logic [31:0] d);
    reg_we_i = 1; reg_num_i = n; reg_wdata_i = d;
    step();
    reg_we_i = 0;
  endtask

  task automatic rd(input logic [4:0] n, output logic [31:0] d);
    reg_num_i = n; #1 d = reg_rdata_o;
  endtask

  task automatic ret();
    eret_i = 1; step(); eret_i = 0;
  endtask

  task automatic raise(input logic [4:0] c, input logic [31:0] pc, input logic bd,
                       input logic [31:0] a);
    exc_valid_i = 1; exc_code_i = c; exc_pc_i = pc; exc_bd_i = bd; exc_addr_i = a;
    #1 chk("R5 redirect", redirect_o, 1);
    step();
    exc_valid_i = 0; exc_bd_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'd12, v); chk("R2 status reset", v, 0);
    rd(5'd13, v); chk("R3 cause reset", v, 0);
    rd(5'd14, v); chk("R1 epc reset", v, 0);
    chk("R4 no redirect at reset", redirect_o, 0);
    chk("R10 handler", handler_pc_o, 32'h8000_0180);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(5'd11, 32'h1234_5678); rd(5'd11, v); chk("R1 compare", v, 32'h1234_5678);
    wr(5'd14, 32'h0000_0abc); rd(5'd14, v); chk("R1 epc write", v, 32'h0000_0abc);
    wr(5'd3, 32'hffff_ffff);  rd(5'd3, v);  chk("R1 unmapped", v, 0);
    wr(5'd12, 32'hffff_ffff); rd(5'd12, v); chk("R2 status fields", v, 32'h0000_ff13);
    wr(5'd12, 0);
    wr(5'd13, 32'hffff_ffff); rd(5'd13, v); chk("R3 cause write", v, 32'h0000_0300);
    wr(5'd13, 0);
  endtask

  task automatic t_pending_unmask();
    logic [31:0] v;
    hw_irq_i = 6'b000100;
    step();
    rd(5'd13, v); chk("R3 masked pending", v[15:8], 8'h10);
    wr(5'd12, 32'h1);
    chk("R4 masked no trap", redirect_o, 0);
    next_pc_i = 32'h400;
    wr(5'd12, 32'h1001);
    #1 chk("R4 unmask trap", redirect_o, 1);
    step();
    rd(5'd14, v); chk("R6 epc next pc", v, 32'h400);
    rd(5'd13, v); chk("R6 code 0", v[6:2], 0);
    rd(5'd12, v); chk("R7 level set", v[1], 1);
    chk("R7 no irq while level", redirect_o, 0);
    hw_irq_i = 0;
    ret();
    rd(5'd12, v); chk("R13 eret clears", v, 32'h1001);
    wr(5'd12, 0);
  endtask

  task automatic t_sync_nested();
    logic [31:0] v;
    raise(5'd4, 32'h1000, 0, 32'hdead_0001);
    rd(5'd14, v); chk("R5 epc", v, 32'h1000);
    rd(5'd13, v); chk("R5 code", v[6:2], 5'd4);
    rd(5'd12, v); chk("R5 level", v[1], 1);
    rd(5'd8, v);  chk("R9 badva load", v, 32'hdead_0001);
    raise(5'd12, 32'h2000, 1, 32'h5555_5555);
    rd(5'd14, v); chk("R7 epc kept", v, 32'h1000);
    rd(5'd13, v); chk("R7 code updated", v[6:2], 5'd12);
    chk("R7 bd kept", v[31], 0);
    rd(5'd8, v);  chk("R9 badva kept", v, 32'hdead_0001);
    ret();
  endtask

  task automatic t_delay();
    logic [31:0] v;
    raise(5'd8, 32'h3008, 1, 0);
    rd(5'd14, v); chk("R8 epc minus 4", v, 32'h3004);
    rd(5'd13, v); chk("R8 bd set", v[31], 1);
    ret();
    raise(5'd5, 32'h3100, 0, 32'h0000_0777);
    rd(5'd13, v); chk("R8 bd cleared", v[31], 0);
    rd(5'd8, v);  chk("R9 store addr error", v, 32'h0000_0777);
    ret();
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(5'd13, 32'h100);
    wr(5'd12, 32'h101);
    next_pc_i = 32'h9990;
    raise(5'd10, 32'h5000, 0, 0);
    rd(5'd13, v); chk("R13 exception wins", v[6:2], 5'd10);
    rd(5'd14, v); chk("R13 epc of exception", v, 32'h5000);
    wr(5'd13, 0);
    wr(5'd12, 0);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    wr(5'd9, 32'd100); rd(5'd9, v); chk("R11 count load", v, 32'd100);
    step();            rd(5'd9, v); chk("R11 count inc", v, 32'd101);
    wr(5'd11, 32'd200);
    wr(5'd9, 32'd195);
    repeat (5) step();
    rd(5'd13, v); chk("R12 not yet", v[15], 0);
    step();
    rd(5'd13, v); chk("R12 match pending", v[15], 1);
    wr(5'd11, 32'd300);
    rd(5'd13, v); chk("R12 compare clears", v[15], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_regmap();
    t_pending_unmask();
    t_sync_nested();
    t_delay();
    t_priority();
    t_timer();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule